// File: doc/BRIEF.md
# Three-Level Serial Word Receiver with Label-Bit Filter

This block takes a 32-bit avionics data word from a three-level differential line. Two comparator outputs stand for the line: one is high on a positive data level and the other on a negative data level. When both are low the line is at its idle level, and when both are high the line is at an illegal level. An internal divider sets the sampling rate from the system clock. A select input picks a bit period of 10 or 80 system clocks, and each bit period holds ten sub-samples. Every data bit is a stable data level followed by an idle stretch. A word ends once 32 bits have been collected.

A completed word can pass through an optional filter. The filter compares word bits 9 and 10 with two configured values, and a word that does not match is thrown away. An accepted word goes into a holding register and raises a ready flag. Software reads the word as two 16-bit halves, each half with its own read strobe. The flag drops once both halves have been read. A partial word that is cut off by a long idle stretch is discarded, and so is a word that contains an illegal level or has two data levels with no idle between them.

Top module: `avw_rx`

## Requirements
- R1: With `slow_sel_i` = 0 the sub-sample period is 1 system clock (bit period 10 clocks). With `slow_sel_i` = 1 it is 8 system clocks (bit period 80 clocks). A line pattern timed for one rate produces no word at the other rate.
- R2: A line level counts only after it has been seen on at least 3 consecutive sub-samples. A data-level pulse of 2 sub-samples inside an idle stretch is ignored and does not corrupt the word.
- R3: Bits are assembled in arrival order, and the first bit received becomes word bit 1. A word is complete after the 32nd bit.
- R4: With `filt_en_i` = 1 a complete word is accepted only when word bit 9 equals `filt_b9_i` and word bit 10 equals `filt_b10_i`. A rejected word leaves `ready_o` and the held word unchanged.
- R5: With `filt_en_i` = 0 every complete word is accepted.
- R6: Half A is shown on `rdata_o` whenever `rd_b_i` = 0. Its bits 15 down to 0 carry word bits 13, 12, 11, 10, 9, 31, 30, 32, 1, 2, 3, 4, 5, 6, 7, 8.
- R7: While `rd_b_i` = 1, `rdata_o` bits 15 down to 0 carry word bits 29 down to 14 (half B).
- R8: An idle stretch of 30 sub-samples (3 bit periods) that arrives after 1 to 31 bits discards the partial word. The next word is then received from its first bit.
- R9: An illegal level (both comparators high for 3 sub-samples), or a data level that becomes stable without an idle level before it, discards the current word. Reception resumes after the next 30-sub-sample idle gap.
- R10: Accepting a word sets `ready_o`. `ready_o` clears on the clock after both `rd_a_i` and `rd_b_i` have each been pulsed, in either order. A word accepted while `ready_o` is set overwrites the held word and restarts the read tracking.
- R11: After reset `ready_o` = 0 and `rdata_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pos_i | input | 1 | Comparator: line at positive data level |
| line_neg_i | input | 1 | Comparator: line at negative data level |
| slow_sel_i | input | 1 | Rate select: 0 = divide by 10, 1 = divide by 80 |
| filt_en_i | input | 1 | Enable the bit 9 / bit 10 filter |
| filt_b9_i | input | 1 | Required value of word bit 9 |
| filt_b10_i | input | 1 | Required value of word bit 10 |
| rd_a_i | input | 1 | Read strobe for half A |
| rd_b_i | input | 1 | Read strobe for half B; also selects half B on `rdata_o` |
| rdata_o | output | 16 | Read data half |
| ready_o | output | 1 | A held word is waiting to be read |

## Verification
Some behaviours hold on every cycle, and the assertions check those. They cover the tick spacing at each rate, that the bit, error and gap events exclude one another, that a word completes only on the 32nd counted bit, and that a gap clears the bit count. They also check that an accepted word always raises the flag, that a rejected word leaves the holding register untouched, and that the flag drops only after a read strobe. Other behaviours need whole line waveforms, so only the bench scenarios can show them. These are the rejection of glitches, the discarding of partial, illegal and null-less words and the recovery after each, a pattern timed for the wrong rate, the scrambled order of half A, and the read sequences that overwrite a held word.

// File: rtl/avw_pkg.sv
// Package avw_pkg
// Shared types and word geometry for the three-level serial word receiver.
// Assumes a 32-bit word that is read back as two 16-bit halves.
package avw_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    // Decoded line level, built from the two comparator outputs
    typedef enum logic [1:0] {
        LV_IDLE = 2'b00,
        LV_POS  = 2'b01,
        LV_NEG  = 2'b10,
        LV_ILL  = 2'b11
    } line_lvl_t;
endpackage

// File: rtl/avw_tick_gen.sv
// Module avw_tick_gen
// Makes a one-cycle sub-sample tick. A bit period is DIV_FAST or DIV_SLOW
// system clocks, and holds SUBS_PER_BIT ticks.
// Assumes both divisors are whole multiples of SUBS_PER_BIT.
module avw_tick_gen #(
    parameter int SUBS_PER_BIT = 10,
    parameter int DIV_FAST     = 10,
    parameter int DIV_SLOW     = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic tick_o
);
    localparam int PER_FAST = DIV_FAST / SUBS_PER_BIT;
    localparam int PER_SLOW = DIV_SLOW / SUBS_PER_BIT;
    localparam int CW       = $clog2(PER_SLOW + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = slow_i ? CW'(PER_SLOW - 1) : CW'(PER_FAST - 1);

    // Count system clocks and pulse the tick once per sub-sample period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= last) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R1: at the slow rate two ticks never fall on adjacent cycles
    p_slow_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && slow_i) |=> (!tick_o || !slow_i));
    // R1: at the fast rate a tick follows every cycle
    p_fast_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_i |=> tick_o);
endmodule

// File: rtl/avw_line_sampler.sv
// Module avw_line_sampler
// Samples the two comparator outputs on every tick and filters each level
// by run length. It emits one-cycle events for a data bit, a framing error
// and an idle gap.
// Assumes each data bit is a data level followed by an idle level.
module avw_line_sampler
    import avw_pkg::*;
#(
    parameter int STABLE_MIN = 3,
    parameter int GAP_SUBS   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pos_i,
    input  logic neg_i,
    output logic bit_vld_o,
    output logic bit_val_o,
    output logic err_o,
    output logic gap_o
);
    localparam int RUN_SAT = GAP_SUBS + 1;
    localparam int RW      = $clog2(RUN_SAT + 1);

    line_lvl_t     lvl;
    line_lvl_t     prev_q;
    logic [RW-1:0] run_q;
    logic [RW-1:0] run_nx;
    logic          armed_q;

    assign lvl    = line_lvl_t'({neg_i, pos_i});
    assign run_nx = (lvl != prev_q)            ? RW'(1) :
                    (run_q == RW'(RUN_SAT))    ? run_q  : run_q + 1'b1;

    // Track run length per level; arm on stable idle, emit events on qualification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= LV_IDLE;
            run_q     <= '0;
            armed_q   <= 1'b0;
            bit_vld_o <= 1'b0;
            bit_val_o <= 1'b0;
            err_o     <= 1'b0;
            gap_o     <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            err_o     <= 1'b0;
            gap_o     <= 1'b0;
            if (tick_i) begin
                prev_q <= lvl;
                run_q  <= run_nx;
                if (run_nx == RW'(STABLE_MIN)) begin
                    case (lvl)
                        LV_IDLE: armed_q <= 1'b1;
                        LV_POS, LV_NEG: begin
                            if (armed_q) begin
                                bit_vld_o <= 1'b1;
                                bit_val_o <= (lvl == LV_POS);
                                armed_q   <= 1'b0;
                            end else begin
                                err_o <= 1'b1;
                            end
                        end
                        default: begin
                            err_o   <= 1'b1;
                            armed_q <= 1'b0;
                        end
                    endcase
                end
                if (lvl == LV_IDLE && run_nx == RW'(GAP_SUBS))
                    gap_o <= 1'b1;
            end
        end
    end

    // R9: bit, error and gap events are mutually exclusive
    p_evt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_vld_o, err_o, gap_o}));
    // R2: every event comes from a sub-sample tick
    p_evt_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_o || err_o || gap_o) |-> $past(tick_i));
endmodule

// File: rtl/avw_deser.sv
// Module avw_deser
// Shifts qualified bits into a word, first bit at word bit 1 (index 0).
// Drops partial words on a gap and drops the whole word after an error
// until the next gap.
// Assumes the bit, error and gap events are one cycle wide and never coincide.
module avw_deser
    import avw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_val_i,
    input  logic              err_i,
    input  logic              gap_i,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CW = $clog2(WORD_W);

    logic [WORD_W-1:0] sr_q;
    logic [CW-1:0]     cnt_q;
    logic              drop_q;
    logic [WORD_W-1:0] sr_nx;

    assign sr_nx = {bit_val_i, sr_q[WORD_W-1:1]};

    // Assemble bits, flush on gap, discard after error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            drop_q <= 1'b0;
            done_o <= 1'b0;
            word_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (err_i) begin
                drop_q <= 1'b1;
                cnt_q  <= '0;
            end else if (gap_i) begin
                drop_q <= 1'b0;
                cnt_q  <= '0;
            end else if (bit_vld_i && !drop_q) begin
                sr_q <= sr_nx;
                if (cnt_q == CW'(WORD_W - 1)) begin
                    cnt_q  <= '0;
                    done_o <= 1'b1;
                    word_o <= sr_nx;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R3: a word completes only on the 32nd counted bit
    p_done_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cnt_q) == CW'(WORD_W - 1) && $past(bit_vld_i)));
    // R8: a gap always clears the partial bit count
    p_gap_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gap_i |=> (cnt_q == '0));
endmodule

// File: rtl/avw_rx.sv
// Module avw_rx (top)
// Three-level serial word receiver: tick divider, level sampler, deserializer,
// label-bit filter, holding register and two-strobe read port.
// Assumes the read strobes are single-cycle pulses. A new accepted word
// overwrites an unread one.
module avw_rx
    import avw_pkg::*;
#(
    parameter int SUBS_PER_BIT = 10,
    parameter int DIV_FAST     = 10,
    parameter int DIV_SLOW     = 80,
    parameter int STABLE_MIN   = 3,
    parameter int GAP_BITS     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pos_i,
    input  logic              line_neg_i,
    input  logic              slow_sel_i,
    input  logic              filt_en_i,
    input  logic              filt_b9_i,
    input  logic              filt_b10_i,
    input  logic              rd_a_i,
    input  logic              rd_b_i,
    output logic [HALF_W-1:0] rdata_o,
    output logic              ready_o
);
    localparam int GAP_SUBS = GAP_BITS * SUBS_PER_BIT;

    // Word bit number (1-based) carried by each bit of half A
    function automatic int half_a_src(input int pos);
        case (pos)
            15: return 13;
            14: return 12;
            13: return 11;
            12: return 10;
            11: return 9;
            10: return 31;
            9:  return 30;
            8:  return 32;
            default: return 8 - pos;
        endcase
    endfunction

    logic              tick;
    logic              bit_vld;
    logic              bit_val;
    logic              err;
    logic              gap;
    logic              done;
    logic [WORD_W-1:0] word;
    logic              match;
    logic [WORD_W-1:0] hold_q;
    logic              seen_a_q;
    logic              seen_b_q;
    logic [HALF_W-1:0] half_a;
    logic [HALF_W-1:0] half_b;

    avw_tick_gen #(
        .SUBS_PER_BIT(SUBS_PER_BIT),
        .DIV_FAST    (DIV_FAST),
        .DIV_SLOW    (DIV_SLOW)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .slow_i(slow_sel_i),
        .tick_o(tick)
    );

    avw_line_sampler #(
        .STABLE_MIN(STABLE_MIN),
        .GAP_SUBS  (GAP_SUBS)
    ) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .pos_i    (line_pos_i),
        .neg_i    (line_neg_i),
        .bit_vld_o(bit_vld),
        .bit_val_o(bit_val),
        .err_o    (err),
        .gap_o    (gap)
    );

    avw_deser u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld_i(bit_vld),
        .bit_val_i(bit_val),
        .err_i    (err),
        .gap_i    (gap),
        .done_o   (done),
        .word_o   (word)
    );

    // Word bits 9 and 10 sit at indices 8 and 9
    assign match = !filt_en_i || (word[8] == filt_b9_i && word[9] == filt_b10_i);

    // Hold accepted words and track which halves have been read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            ready_o  <= 1'b0;
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else if (done && match) begin
            hold_q   <= word;
            ready_o  <= 1'b1;
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else if (ready_o) begin
            if ((seen_a_q || rd_a_i) && (seen_b_q || rd_b_i)) begin
                ready_o  <= 1'b0;
                seen_a_q <= 1'b0;
                seen_b_q <= 1'b0;
            end else begin
                seen_a_q <= seen_a_q || rd_a_i;
                seen_b_q <= seen_b_q || rd_b_i;
            end
        end
    end

    // Build both read halves from the held word
    for (genvar i = 0; i < HALF_W; i++) begin : g_halves
        assign half_a[i] = hold_q[half_a_src(i) - 1];
        assign half_b[i] = hold_q[i + 13];
    end

    assign rdata_o = rd_b_i ? half_b : half_a;

    // R5: an accepted word is held and flagged on the next cycle
    p_accept_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && match) |=> (ready_o && hold_q == $past(word)));
    // R4: a filtered-out word leaves the holding register untouched
    p_reject_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !match) |=> $stable(hold_q));
    // R10: the flag only drops after a read strobe
    p_ready_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> ($past(rd_a_i) || $past(rd_b_i)));
endmodule

// File: tb/avw_rx_tb.sv
`timescale 1ns/1ps
module avw_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_pos = 1'b0;
    logic        line_neg = 1'b0;
    logic        slow_sel = 1'b0;
    logic        filt_en = 1'b0;
    logic        filt_b9 = 1'b0;
    logic        filt_b10 = 1'b0;
    logic        rd_a = 1'b0;
    logic        rd_b = 1'b0;
    logic [15:0] rdata;
    logic        ready;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_acc = '0;

    always #2 clk = ~clk;

    avw_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_pos_i(line_pos),
        .line_neg_i(line_neg),
        .slow_sel_i(slow_sel),
        .filt_en_i (filt_en),
        .filt_b9_i (filt_b9),
        .filt_b10_i(filt_b10),
        .rd_a_i    (rd_a),
        .rd_b_i    (rd_b),
        .rdata_o   (rdata),
        .ready_o   (ready)
    );

    function automatic logic [15:0] exp_a(input logic [31:0] w);
        return {w[12], w[11], w[10], w[9], w[8], w[30], w[29], w[31],
                w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
    endfunction

    function automatic logic [15:0] exp_b(input logic [31:0] w);
        return w[28:13];
    endfunction

    function automatic logic exp_accept(input logic [31:0] w, input logic en,
                                        input logic b9, input logic b10);
        return !en || (w[8] == b9 && w[9] == b10);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_lvl(input logic p, input logic n, input int subs, input int per);
        line_pos = p;
        line_neg = n;
        repeat (subs * per) @(negedge clk);
    endtask

    // mode 0 normal, 1 glitch in idle, 2 illegal level, 3 missing idle
    task automatic send_word(input logic [31:0] w, input int nbits, input int per,
                             input int mode);
        for (int k = 0; k < nbits; k++) begin
            hold_lvl(w[k], !w[k], 5, per);
            if (mode == 2 && k == 12) hold_lvl(1'b1, 1'b1, 4, per);
            if (mode == 3 && k == 20) begin
            end else if (mode == 1) begin
                hold_lvl(1'b0, 1'b0, 1, per);
                hold_lvl(1'b1, 1'b0, 2, per);
                hold_lvl(1'b0, 1'b0, 5, per);
            end else begin
                hold_lvl(1'b0, 1'b0, 5, per);
            end
        end
        hold_lvl(1'b0, 1'b0, 40, per);
    endtask

    // Read both halves, A then B, and confirm the flag drops
    task automatic read_check(input logic [31:0] w, input string req);
        rd_a = 1'b1;
        #1;
        chk(rdata == exp_a(w), {req, " R6 half A"}, 32'(rdata), 32'(exp_a(w)));
        @(negedge clk);
        rd_a = 1'b0;
        rd_b = 1'b1;
        #1;
        chk(rdata == exp_b(w), {req, " R7 half B"}, 32'(rdata), 32'(exp_b(w)));
        @(negedge clk);
        rd_b = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, {req, " R10 ready cleared"}, 32'(ready), 32'd0);
    endtask

    task automatic expect_word(input logic [31:0] w, input logic acc, input string req);
        if (acc) begin
            chk(ready == 1'b1, {req, " ready set"}, 32'(ready), 32'd1);
            read_check(w, req);
            last_acc = w;
        end else begin
            chk(ready == 1'b0, {req, " word dropped"}, 32'(ready), 32'd0);
            chk(rdata == exp_a(last_acc), {req, " held word kept"}, 32'(rdata),
                32'(exp_a(last_acc)));
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1ce5eed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R11 reset ready", 32'(ready), 32'd0);
        chk(rdata == 16'h0, "R11 reset rdata", 32'(rdata), 32'd0);
        hold_lvl(1'b0, 1'b0, 10, 1);

        // R3 R5: plain word, filter off
        send_word(32'hA5C3_1E69, 32, 1, 0);
        expect_word(32'hA5C3_1E69, 1'b1, "R3 R5 basic");
        send_word(32'h0000_0001, 32, 1, 0);
        expect_word(32'h0000_0001, 1'b1, "R3 first bit");
        send_word(32'h8000_0000, 32, 1, 0);
        expect_word(32'h8000_0000, 1'b1, "R3 last bit");

        // R4: filter mismatch, then match
        filt_en = 1'b1;
        filt_b9 = 1'b1;
        filt_b10 = 1'b0;
        send_word(32'h0000_0200, 32, 1, 0);
        expect_word(32'h0000_0200, 1'b0, "R4 mismatch");
        send_word(32'h1234_5100, 32, 1, 0);
        expect_word(32'h1234_5100, 1'b1, "R4 match");
        filt_en = 1'b0;

        // R8: partial word then full word
        send_word(32'hFFFF_FFFF, 20, 1, 0);
        expect_word(32'hFFFF_FFFF, 1'b0, "R8 partial");
        send_word(32'h3C3C_5A5A, 32, 1, 0);
        expect_word(32'h3C3C_5A5A, 1'b1, "R8 recover");

        // R9: illegal level and missing idle, each followed by recovery
        send_word(32'hDEAD_BEEF, 32, 1, 2);
        expect_word(32'hDEAD_BEEF, 1'b0, "R9 illegal");
        send_word(32'h0F0F_00FF, 32, 1, 0);
        expect_word(32'h0F0F_00FF, 1'b1, "R9 recover");
        send_word(32'h0010_0000, 32, 1, 3);
        expect_word(32'h0010_0000, 1'b0, "R9 no idle");
        send_word(32'h7654_3210, 32, 1, 0);
        expect_word(32'h7654_3210, 1'b1, "R9 recover2");

        // R2: short glitches inside idle stretches
        send_word(32'h9ABC_DEF0, 32, 1, 1);
        expect_word(32'h9ABC_DEF0, 1'b1, "R2 glitch");

        // R1: slow rate rejects fast timing, accepts slow timing
        slow_sel = 1'b1;
        hold_lvl(1'b0, 1'b0, 10, 8);
        send_word(32'h5555_AAAA, 32, 1, 0);
        expect_word(32'h5555_AAAA, 1'b0, "R1 fast pattern at slow rate");
        send_word(32'hC001_D00D, 32, 8, 0);
        expect_word(32'hC001_D00D, 1'b1, "R1 slow");
        slow_sel = 1'b0;
        hold_lvl(1'b0, 1'b0, 10, 1);

        // R10: overwrite while ready, reads in B-then-A order
        send_word(32'h1111_2222, 32, 1, 0);
        rd_b = 1'b1;
        @(negedge clk);
        rd_b = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R10 one half read", 32'(ready), 32'd1);
        send_word(32'h3333_4444, 32, 1, 0);
        chk(ready == 1'b1, "R10 overwrite ready", 32'(ready), 32'd1);
        rd_a = 1'b1;
        @(negedge clk);
        rd_a = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R10 tracking restarted", 32'(ready), 32'd1);
        rd_b = 1'b1;
        #1;
        chk(rdata == exp_b(32'h3333_4444), "R10 R7 overwritten half B", 32'(rdata),
            32'(exp_b(32'h3333_4444)));
        @(negedge clk);
        rd_b = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R10 cleared B-A order", 32'(ready), 32'd0);
        last_acc = 32'h3333_4444;

        // Random words with random filter settings and rate
        for (int i = 0; i < 20; i++) begin
            logic [31:0] w;
            logic        s;
            int          per;
            w = $urandom;
            s = ($urandom % 4) == 0;
            filt_en = $urandom % 2;
            filt_b9 = $urandom % 2;
            filt_b10 = $urandom % 2;
            slow_sel = s;
            per = s ? 8 : 1;
            hold_lvl(1'b0, 1'b0, 5, per);
            send_word(w, 32, per, 0);
            expect_word(w, exp_accept(w, filt_en, filt_b9, filt_b10), "R4 R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule